// File: doc/BRIEF.md
# Packed-Index Vector Element Gather

This block is a small sequencer wrapped around a 32-entry, 64-bit register file. One command moves a run of registers under the control of an index list. The command names a destination base register, the first register of the index list, a vector length and a subvector length. It also carries a 4-bit function code that picks the iteration mode and the width of each index. The sequencer makes one move per clock. Each move reads the next index from the list, adds it to the destination base, and copies the register found there into the next destination slot.

Indices can be packed several to a register, 8, 16 or 32 bits each, or stored one per register at full width. They are taken from the least significant end first, and the list continues into the next-higher register when one register is used up. The index width has no effect on the data: every move copies a whole 64-bit register. In normal mode, each move takes a fresh index. In subvector mode, the index position goes back to zero at the start of every outer element, so the same few indices are reused for each group. This is what a transposition needs.

Software fills and inspects the register file through a simple write port and a combinational read port. It starts a command with a start strobe and waits for a one-cycle done pulse.

Top module: `pidx_gather`

## Requirements
- R1: After reset, busy, done and rej are low and every register reads back as zero.
- R2: When busy is low, a host write (host_we) stores host_wdata in register host_waddr. host_rdata always shows the current contents of register host_raddr with no clock delay.
- R3: A start with func[0] = 0 is rejected. This includes 0000, which belongs to another operation. rej is high for exactly the one cycle after the start edge, busy stays low, and no register changes. func[1:0] = 01 selects normal mode and 11 selects subvector mode.
- R4: func[3:2] is the index width code: 0 means 64 bits, 1 means 8, 2 means 16 and 3 means 32. Index number k is the W-bit field at bit offset k*W of the concatenation of registers idx_base, idx_base+1, and so on, with the least significant bit first. Register numbers wrap modulo 32.
- R5: Move number m (counting from 0) writes the register at (dst_base + m) mod 32. The value written is the full 64-bit register at (dst_base + index) mod 32, read as it stands when that move runs. Moves run in order: the outer element i first, then the inner element j within it.
- R6: In normal mode, move m uses index number k = m, counted across all vlen * (svl_m1+1) moves.
- R7: In subvector mode, move m = i*(svl_m1+1)+j uses index number k = j. The index position restarts at zero for every outer element.
- R8: After an accepted start with vlen > 0, busy is high for exactly vlen*(svl_m1+1) cycles. done is high for exactly one cycle, the cycle after the last move, and is never high together with busy.
- R9: A start while busy is ignored. The running command's moves, timing and results are unchanged.
- R10: A host write while busy is ignored. The addressed register keeps its value.
- R11: An accepted start with vlen = 0 makes no moves. busy stays low and done pulses in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled while idle |
| func | input | 4 | [3:2] index width code, [1] subvector mode, [0] must be 1 |
| dst_base | input | 5 | Destination base register |
| idx_base | input | 5 | First register of the packed index list |
| vlen | input | 6 | Number of outer elements (0 to 32) |
| svl_m1 | input | 2 | Subvector length minus one |
| host_we | input | 1 | Host write enable |
| host_waddr | input | 5 | Host write register |
| host_wdata | input | 64 | Host write data |
| host_raddr | input | 5 | Host read register |
| host_rdata | output | 64 | Host read data, combinational |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rej | output | 1 | One-cycle pulse for a rejected function code |

## Verification
The packed example 0x00020301 at 8 bits checks least-significant-first order within a register. 16-bit and 32-bit lists that spill into a second register check the carry to the next register. A full-width list that starts at register 31 checks wrapping and that only the low five bits of an index are used. Subvector runs at two widths separate index reuse from the normal running count. A 128-move run overwrites its own index registers partway through, which separates true in-order behaviour from a design that reads all indices up front. Rejected codes, a zero length, and start strobes and host writes issued mid-run check that the register file is left alone when it should be.

// File: rtl/pidx_gather_pkg.sv
package pidx_gather_pkg;

    // Index width code carried in the top two function bits
    typedef enum logic [1:0] {
        IW_FULL = 2'd0,
        IW_B8   = 2'd1,
        IW_B16  = 2'd2,
        IW_B32  = 2'd3
    } idx_width_e;

    // log2 of the index width in bits
    function automatic logic [3:0] iw_shift(input logic [1:0] code, input logic [3:0] full_sh);
        case (idx_width_e'(code))
            IW_FULL: iw_shift = full_sh;
            IW_B8:   iw_shift = 4'd3;
            IW_B16:  iw_shift = 4'd4;
            default: iw_shift = 4'd5;
        endcase
    endfunction

endpackage

// File: rtl/pidx_gather_rf.sv
module pidx_gather_rf #(
    parameter int NREG = 32,
    parameter int XLEN = 64,
    parameter int NRD  = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [$clog2(NREG)-1:0]            waddr,
    input  logic [XLEN-1:0]                    wdata,
    input  logic [NRD-1:0][$clog2(NREG)-1:0]   raddr,
    output logic [NRD-1:0][XLEN-1:0]           rdata
);
    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] rf_d [NREG];
    logic [XLEN-1:0] rf_q [NREG];

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            rf_d[r] = rf_q[r];
        end
        if (we) begin
            rf_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) rf_q[r] <= '0;
            else        rf_q[r] <= rf_d[r];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = rf_q[raddr[p][AW-1:0]];
    end

endmodule

// File: rtl/pidx_gather_unpack.sv
module pidx_gather_unpack #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         word,
    input  logic [$clog2(XLEN)-1:0] shift,
    input  logic [1:0]              code,
    output logic [XLEN-1:0]         idx
);
    import pidx_gather_pkg::*;

    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] shifted;

    always_comb begin
        case (idx_width_e'(code))
            IW_FULL: mask = '1;
            IW_B8:   mask = XLEN'(8'hFF);
            IW_B16:  mask = XLEN'(16'hFFFF);
            default: mask = XLEN'(32'hFFFF_FFFF);
        endcase
        shifted = word >> shift;
        idx     = shifted & mask;
    end

endmodule

// File: rtl/pidx_gather_seq.sv
module pidx_gather_seq #(
    parameter int NREG  = 32,
    parameter int XLEN  = 64,
    parameter int VL_W  = 6,
    parameter int SVL_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [3:0]                func,
    input  logic [$clog2(NREG)-1:0]   dst_base,
    input  logic [$clog2(NREG)-1:0]   idx_base,
    input  logic [VL_W-1:0]           vlen,
    input  logic [SVL_W-1:0]          svl_m1,
    output logic                      busy,
    output logic                      done,
    output logic                      rej,
    output logic [$clog2(NREG)-1:0]   idx_raddr,
    output logic [$clog2(XLEN)-1:0]   idx_shift,
    output logic [1:0]                idx_code,
    output logic [$clog2(NREG)-1:0]   dbase,
    output logic                      mv_we,
    output logic [$clog2(NREG)-1:0]   mv_waddr
);
    import pidx_gather_pkg::*;

    localparam int AW    = $clog2(NREG);
    localparam int LXW   = $clog2(XLEN);
    localparam int MW    = VL_W + SVL_W;
    localparam int OFF_W = MW + LXW;
    localparam logic [3:0] FULL_SH = 4'(LXW);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             rej;
        logic             sub;
        logic [1:0]       code;
        logic [AW-1:0]    dbase;
        logic [AW-1:0]    ibase;
        logic [VL_W-1:0]  vl;
        logic [VL_W-1:0]  i;
        logic [SVL_W-1:0] svm1;
        logic [SVL_W-1:0] j;
        logic [MW-1:0]    m;
    } seq_t;

    seq_t s_d, s_q;

    logic [MW-1:0]    k;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] word_off;
    logic             last;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.rej  = 1'b0;

        // index position: running count or restarting per outer element
        k        = s_q.sub ? MW'(s_q.j) : s_q.m;
        off      = OFF_W'(k) << iw_shift(s_q.code, FULL_SH);
        word_off = off >> LXW;
        last     = (s_q.j == s_q.svm1) && (s_q.i == s_q.vl - VL_W'(1));

        if (s_q.busy) begin
            if (last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.m = s_q.m + MW'(1);
                if (s_q.j == s_q.svm1) begin
                    s_d.j = '0;
                    s_d.i = s_q.i + VL_W'(1);
                end else begin
                    s_d.j = s_q.j + SVL_W'(1);
                end
            end
        end else if (start) begin
            if (!func[0]) begin
                s_d.rej = 1'b1;
            end else if (vlen == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy  = 1'b1;
                s_d.sub   = func[1];
                s_d.code  = func[3:2];
                s_d.dbase = dst_base;
                s_d.ibase = idx_base;
                s_d.vl    = vlen;
                s_d.svm1  = svl_m1;
                s_d.i     = '0;
                s_d.j     = '0;
                s_d.m     = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign rej       = s_q.rej;
    assign idx_raddr = s_q.ibase + word_off[AW-1:0];
    assign idx_shift = off[LXW-1:0];
    assign idx_code  = s_q.code;
    assign dbase     = s_q.dbase;
    assign mv_we     = s_q.busy;
    assign mv_waddr  = s_q.dbase + s_q.m[AW-1:0];

endmodule

// File: rtl/pidx_gather.sv
module pidx_gather #(
    parameter int NREG  = 32,
    parameter int XLEN  = 64,
    parameter int VL_W  = 6,
    parameter int SVL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [3:0]              func,
    input  logic [$clog2(NREG)-1:0] dst_base,
    input  logic [$clog2(NREG)-1:0] idx_base,
    input  logic [VL_W-1:0]         vlen,
    input  logic [SVL_W-1:0]        svl_m1,
    input  logic                    host_we,
    input  logic [$clog2(NREG)-1:0] host_waddr,
    input  logic [XLEN-1:0]         host_wdata,
    input  logic [$clog2(NREG)-1:0] host_raddr,
    output logic [XLEN-1:0]         host_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    rej
);
    localparam int AW  = $clog2(NREG);
    localparam int LXW = $clog2(XLEN);
    localparam int NRD = 3;

    logic [NRD-1:0][AW-1:0]   rf_raddr;
    logic [NRD-1:0][XLEN-1:0] rf_rdata;
    logic [AW-1:0]            idx_raddr;
    logic [LXW-1:0]           idx_shift;
    logic [1:0]               idx_code;
    logic [AW-1:0]            dbase;
    logic                     mv_we;
    logic [AW-1:0]            mv_waddr;
    logic [XLEN-1:0]          idx_val;
    logic [AW-1:0]            src_raddr;
    logic                     rf_we;
    logic [AW-1:0]            rf_waddr;
    logic [XLEN-1:0]          rf_wdata;

    pidx_gather_seq #(
        .NREG(NREG), .XLEN(XLEN), .VL_W(VL_W), .SVL_W(SVL_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .func      (func),
        .dst_base  (dst_base),
        .idx_base  (idx_base),
        .vlen      (vlen),
        .svl_m1    (svl_m1),
        .busy      (busy),
        .done      (done),
        .rej       (rej),
        .idx_raddr (idx_raddr),
        .idx_shift (idx_shift),
        .idx_code  (idx_code),
        .dbase     (dbase),
        .mv_we     (mv_we),
        .mv_waddr  (mv_waddr)
    );

    pidx_gather_unpack #(.XLEN(XLEN)) u_unpack (
        .word  (rf_rdata[0]),
        .shift (idx_shift),
        .code  (idx_code),
        .idx   (idx_val)
    );

    // source register: destination base plus index, wrapping in the file
    assign src_raddr = dbase + idx_val[AW-1:0];

    assign rf_raddr[0] = idx_raddr;
    assign rf_raddr[1] = src_raddr;
    assign rf_raddr[2] = host_raddr;
    assign host_rdata  = rf_rdata[2];

    // moves own the write port while busy; host writes are dropped then
    assign rf_we    = mv_we | host_we;
    assign rf_waddr = mv_we ? mv_waddr : host_waddr;
    assign rf_wdata = mv_we ? rf_rdata[1] : host_wdata;

    pidx_gather_rf #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

endmodule

// File: rtl/pidx_gather_chk.sv
module pidx_gather_chk #(
    parameter int VL_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [3:0]      func,
    input logic [VL_W-1:0] vlen,
    input logic            busy,
    input logic            done,
    input logic            rej
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !func[0]) |=> (rej && !busy && !done));

    // R3
    rej_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej |=> !rej);

    // R11
    empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && func[0] && vlen == '0) |=> (done && !busy));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && func[0] && vlen != '0) |=> (busy && !rej));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !rej);

endmodule

bind pidx_gather pidx_gather_chk #(.VL_W(VL_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .func  (func),
    .vlen  (vlen),
    .busy  (busy),
    .done  (done),
    .rej   (rej)
);

// File: tb/tb_pidx_gather.sv
module tb_pidx_gather;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  func = '0;
    logic [4:0]  dst_base = '0;
    logic [4:0]  idx_base = '0;
    logic [5:0]  vlen = '0;
    logic [1:0]  svl_m1 = '0;
    logic        host_we = 1'b0;
    logic [4:0]  host_waddr = '0;
    logic [63:0] host_wdata = '0;
    logic [4:0]  host_raddr = '0;
    logic [63:0] host_rdata;
    logic        busy, done, rej;

    int checks = 0;
    int errors = 0;
    logic [63:0] mdl [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    pidx_gather dut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .dst_base(dst_base), .idx_base(idx_base), .vlen(vlen), .svl_m1(svl_m1),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .busy(busy), .done(done), .rej(rej)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        mdl[a] = d;
    endtask

    task automatic fill_pattern(input logic [63:0] seed);
        for (int r = 0; r < 32; r++) begin
            host_write(5'(r), seed ^ (64'h0101_0101_0000_0000 * 64'(r + 1)) ^ 64'(r * 7));
        end
    endtask

    task automatic check_all(input string req);
        for (int r = 0; r < 32; r++) begin
            host_raddr = 5'(r);
            #1;
            chk(host_rdata === mdl[r], req, $sformatf("reg%0d", r), host_rdata, mdl[r]);
        end
    endtask

    // Reference model built from R4..R7
    task automatic model_op(input logic [3:0] f, input logic [4:0] db, input logic [4:0] ib,
                            input logic [5:0] vl, input logic [1:0] svm1);
        int w;
        logic [63:0] msk;
        w = (f[3:2] == 2'd0) ? 64 : (4 << f[3:2]);
        msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int i = 0; i < int'(vl); i++) begin
            for (int j = 0; j <= int'(svm1); j++) begin
                int m, k, off;
                logic [4:0] r, src, dst;
                logic [63:0] ix;
                m   = i * (int'(svm1) + 1) + j;
                k   = f[1] ? j : m;
                off = k * w;
                r   = 5'((int'(ib) + off / 64) % 32);
                ix  = (mdl[r] >> (off % 64)) & msk;
                src = db + ix[4:0];
                dst = 5'((int'(db) + m) % 32);
                mdl[dst] = mdl[src];
            end
        end
    endtask

    // glitch: 0 none, 1 extra start mid-run, 2 host write mid-run
    task automatic run_op(input logic [3:0] f, input logic [4:0] db, input logic [4:0] ib,
                          input logic [5:0] vl, input logic [1:0] svm1,
                          input int glitch, input string req);
        int cyc, n;
        n = int'(vl) * (int'(svm1) + 1);
        model_op(f, db, ib, vl, svm1);
        @(negedge clk);
        func = f; dst_base = db; idx_base = ib; vlen = vl; svl_m1 = svm1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
        cyc = 0;
        while (busy && cyc < 1000) begin
            if (cyc == 2 && glitch == 1) begin
                // R9: different command while busy must be ignored
                func = 4'b0001; dst_base = 5'd1; idx_base = 5'd2; vlen = 6'd9; start = 1'b1;
            end else if (cyc == 2 && glitch == 2) begin
                // R10: host write while busy must be ignored
                host_we = 1'b1; host_waddr = 5'd25; host_wdata = 64'hDEAD_BEEF_0BAD_F00D;
            end else begin
                start = 1'b0; host_we = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; host_we = 1'b0;
        chk(cyc == n, "R8", "busy cycles", 64'(cyc), 64'(n));
        chk(done === 1'b1, "R8", "done after last move", 64'(done), 64'd1);
        @(negedge clk);
        chk(done === 1'b0, "R8", "done single cycle", 64'(done), 64'd0);
        check_all(req);
    endtask

    task automatic test_reset;
        chk(busy === 1'b0 && done === 1'b0 && rej === 1'b0, "R1", "status idle",
            {61'd0, busy, done, rej}, 64'd0);
        for (int r = 0; r < 32; r++) mdl[r] = '0;
        check_all("R1");
    endtask

    task automatic test_host_port;
        host_write(5'd7, 64'h1234_5678_9ABC_DEF0);
        host_write(5'd30, 64'hFFFF_0000_FFFF_0000);
        check_all("R2");
    endtask

    task automatic test_packed8_normal;
        fill_pattern(64'hA5A5_0000_1111_0000);
        host_write(5'd8, 64'h0000_0000_0002_0301);
        run_op(4'b0101, 5'd3, 5'd8, 6'd4, 2'd0, 0, "R6");
        // R4: indices 1,3,2,0 give dest 3..6 = old r4, r6, r5, then r3 (now old r4)
    endtask

    task automatic test_cross16;
        fill_pattern(64'h0F0F_2222_0000_3333);
        host_write(5'd20, 64'h0002_0005_0001_0003);
        host_write(5'd21, 64'h0006_0004_0007_0000);
        run_op(4'b1001, 5'd0, 5'd20, 6'd8, 2'd0, 0, "R4");
    endtask

    task automatic test_sub32;
        fill_pattern(64'h3C3C_4444_5555_0000);
        host_write(5'd28, 64'h0000_0003_0000_0001);
        host_write(5'd29, 64'h0000_0000_0000_0002);
        run_op(4'b1111, 5'd10, 5'd28, 6'd3, 2'd3, 0, "R7");
    endtask

    task automatic test_full_wrap;
        fill_pattern(64'h7777_0000_8888_9999);
        host_write(5'd31, 64'hFFFF_0000_0000_0005);
        host_write(5'd0,  64'd33);
        run_op(4'b0001, 5'd30, 5'd31, 6'd2, 2'd0, 0, "R5");
    endtask

    task automatic test_sub8_transpose;
        fill_pattern(64'h1357_9BDF_2468_ACE0);
        host_write(5'd4, 64'h0000_0000_0001_0203);
        run_op(4'b0111, 5'd12, 5'd4, 6'd4, 2'd3, 0, "R7");
    endtask

    task automatic test_long_overlap;
        fill_pattern(64'hCAFE_0000_BABE_0000);
        for (int r = 20; r < 32; r++) host_write(5'(r), 64'h0B1D_0713_1F02_1A05 + 64'(r * 64'h0301_0502_0104_0203));
        for (int r = 0; r < 4; r++) host_write(5'(r), 64'h1E03_0916_0C1B_1108 ^ 64'(r * 64'h0707_0707));
        run_op(4'b0101, 5'd0, 5'd20, 6'd32, 2'd3, 0, "R5");
    endtask

    task automatic test_start_busy;
        fill_pattern(64'h5A5A_6B6B_7C7C_8D8D);
        host_write(5'd16, 64'h0000_0000_0001_0002);
        run_op(4'b0101, 5'd5, 5'd16, 6'd6, 2'd0, 1, "R9");
    endtask

    task automatic test_host_busy;
        fill_pattern(64'h9999_AAAA_BBBB_CCCC);
        host_write(5'd18, 64'h0000_0000_0101_0101);
        run_op(4'b0101, 5'd2, 5'd18, 6'd6, 2'd0, 2, "R10");
    endtask

    task automatic test_reject(input logic [3:0] f);
        fill_pattern(64'hEEEE_1111_DDDD_2222);
        @(negedge clk);
        func = f; dst_base = 5'd0; idx_base = 5'd1; vlen = 6'd4; svl_m1 = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rej === 1'b1, "R3", $sformatf("rej for func %b", f), 64'(rej), 64'd1);
        chk(busy === 1'b0, "R3", "busy stays low", 64'(busy), 64'd0);
        @(negedge clk);
        chk(rej === 1'b0, "R3", "rej single cycle", 64'(rej), 64'd0);
        chk(busy === 1'b0 && done === 1'b0, "R3", "no run", {62'd0, busy, done}, 64'd0);
        check_all("R3");
    endtask

    task automatic test_zero_len;
        @(negedge clk);
        func = 4'b0101; dst_base = 5'd0; idx_base = 5'd1; vlen = 6'd0; svl_m1 = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1, "R11", "done after empty start", 64'(done), 64'd1);
        chk(busy === 1'b0, "R11", "busy low", 64'(busy), 64'd0);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R11", "idle after", {62'd0, busy, done}, 64'd0);
        check_all("R11");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_host_port();
        test_packed8_normal();
        test_cross16();
        test_sub32();
        test_full_wrap();
        test_sub8_transpose();
        test_long_overlap();
        test_start_busy();
        test_host_busy();
        test_reject(4'b0000);
        test_reject(4'b1110);
        test_zero_len();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule